// File: doc/BRIEF.md
# Four-Phase Modulation Sequencer and Demodulator

This block drives the switch pattern of a sensor front end that combines current spinning with a reference coil. The sensor is then read through a four-phase cycle that repeats with no gap. On every phase step the block advances its phase and drives two control bits. One bit sets the spin direction and the other sets the polarity of the coil current. The block takes one signed amplifier sample for the phase that is ending.

The block holds three accumulators. Each one multiplies each sample by +1 or -1, using its own sign pattern over the four phases, and adds the result. The three patterns are orthogonal. So one sample stream is split into three parts: the external field term, the coil reference term and the constant offset. Each part comes out scaled by four. After the fourth phase step the three sums are registered and a one-cycle strobe marks them. The accumulators restart at once, so the next cycle loses no sample.

The expected samples over phases 0 to 3 are +(e+r)+o, -(e+r)+o, +(e-r)+o and -(e-r)+o. Here e is the external term, r the reference term and o the offset. With these inputs the three outputs are 4e, 4r and 4o.

Top module: `quad_phase_demod`

## Requirements
- R1: While rst_ni is low, phase_o is 0, spin_o and coil_o are 1, res_valid_o is 0, and sig_o, ref_o and off_o are 0.
- R2: phase_o advances by one (3 wraps to 0) on each rising clock edge where step_i is 1. It holds when step_i is 0.
- R3: spin_o is 1 in phases 0 and 2 and 0 in phases 1 and 3, so it toggles on every step.
- R4: coil_o is 1 in phases 0 and 1 and 0 in phases 2 and 3.
- R5: With s0..s3 the samples taken in phases 0..3 of one cycle, sig_o = s0 - s1 + s2 - s3.
- R6: ref_o = s0 - s1 - s2 + s3 over the same cycle.
- R7: off_o = s0 + s1 + s2 + s3 over the same cycle.
- R8: res_valid_o is 1 for exactly the one cycle after the edge that takes the phase-3 sample. The three result ports change only at that edge.
- R9: The results are exact for any sample values, including full-scale positive and the most negative code. The results are SAMPLE_W+2 bits, two's complement.
- R10: sample_i has no effect when step_i is 0. A phase-0 step that directly follows the phase-3 step goes into the new cycle with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Phase step: take sample_i for the current phase and advance |
| sample_i | input | SAMPLE_W | Signed amplifier sample for the current phase |
| phase_o | output | 2 | Current phase, 0 to 3 |
| spin_o | output | 1 | Spin-direction control |
| coil_o | output | 1 | Coil-current polarity control |
| res_valid_o | output | 1 | One-cycle strobe marking new results |
| sig_o | output | SAMPLE_W+2 | Demodulated external term (x4) |
| ref_o | output | SAMPLE_W+2 | Demodulated reference term (x4) |
| off_o | output | SAMPLE_W+2 | Demodulated offset (x4) |

## Verification
phase_o, spin_o and coil_o show the new phase one edge after a step. The three results and res_valid_o appear one edge after the phase-3 step. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, the first point where every one-register path has settled. At that point it compares every output against its model, each cycle, including idle cycles. This checks the one-cycle strobe and confirms that the results hold between updates. Idle cycles carry random samples, to show that they are ignored.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  typedef logic [1:0] phase_t;

  localparam phase_t PH_LAST = 2'd3;

  // bit p set: sample of phase p is negated
  localparam logic [3:0] NEG_SIG = 4'b1010;
  localparam logic [3:0] NEG_REF = 4'b0110;
  localparam logic [3:0] NEG_OFF = 4'b0000;
  localparam int unsigned NUM_CH = 3;

  function automatic logic [3:0] ch_mask(input int unsigned ch);
    case (ch)
      0:       return NEG_SIG;
      1:       return NEG_REF;
      default: return NEG_OFF;
    endcase
  endfunction
endpackage

// File: rtl/qpd_sequencer.sv
module qpd_sequencer
  import qpd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  output phase_t phase_o,
  output logic   last_o,
  output logic   spin_o,
  output logic   coil_o
);
  phase_t phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= phase_q + 2'd1;
  end

  assign phase_o = phase_q;
  assign last_o  = step_i && (phase_q == PH_LAST);
  assign spin_o  = ~phase_q[0];
  assign coil_o  = ~phase_q[1];
endmodule

// File: rtl/qpd_channel_acc.sv
module qpd_channel_acc
  import qpd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter logic [3:0]  NEG_MASK = 4'b0000,
  localparam int unsigned ACC_W   = SAMPLE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                last_i,
  input  phase_t              phase_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [ACC_W-1:0]    res_o
);
  logic signed [ACC_W-1:0] sx, term, acc_q, sum;

  assign sx   = {{2{sample_i[SAMPLE_W-1]}}, sample_i};
  assign term = NEG_MASK[phase_i] ? -sx : sx;
  assign sum  = acc_q + term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_o <= '0;
    end else if (step_i) begin
      if (last_i) begin
        res_o <= sum;
        acc_q <= '0;
      end else begin
        acc_q <= sum;
      end
    end
  end
endmodule

// File: rtl/quad_phase_demod.sv
module quad_phase_demod
  import qpd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned ACC_W   = SAMPLE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [1:0]          phase_o,
  output logic                spin_o,
  output logic                coil_o,
  output logic                res_valid_o,
  output logic [ACC_W-1:0]    sig_o,
  output logic [ACC_W-1:0]    ref_o,
  output logic [ACC_W-1:0]    off_o
);
  phase_t            phase;
  logic              last;
  logic [ACC_W-1:0]  res [NUM_CH];

  qpd_sequencer u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .phase_o(phase),
    .last_o (last),
    .spin_o (spin_o),
    .coil_o (coil_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qpd_channel_acc #(
      .SAMPLE_W(SAMPLE_W),
      .NEG_MASK(ch_mask(c))
    ) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_i),
      .last_i  (last),
      .phase_i (phase),
      .sample_i(sample_i),
      .res_o   (res[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_valid_o <= 1'b0;
    else         res_valid_o <= last;
  end

  assign phase_o = phase;
  assign sig_o   = res[0];
  assign ref_o   = res[1];
  assign off_o   = res[2];
endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int unsigned AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic [1:0]    phase_o,
  input logic          spin_o,
  input logic          coil_o,
  input logic          res_valid_o,
  input logic [AW-1:0] sig_o,
  input logic [AW-1:0] ref_o,
  input logic [AW-1:0] off_o
);
  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> phase_o == 2'($past(phase_o) + 2'd1));

  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_o));

  assert_spin_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> spin_o != $past(spin_o));

  assert_coil_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_o[0]) |=> coil_o != $past(coil_o));

  assert_valid_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_o == 2'd3) |=> res_valid_o);

  assert_valid_only_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && phase_o == 2'd3) |=> !res_valid_o);

  assert_results_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && phase_o == 2'd3) |=> ($stable(sig_o) && $stable(ref_o) && $stable(off_o)));
endmodule

bind quad_phase_demod qpd_checker #(.AW(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .phase_o    (phase_o),
  .spin_o     (spin_o),
  .coil_o     (coil_o),
  .res_valid_o(res_valid_o),
  .sig_o      (sig_o),
  .ref_o      (ref_o),
  .off_o      (off_o)
);

// File: tb/sim_quad_phase_demod.sv
`timescale 1ns/1ps
module sim_quad_phase_demod;
  localparam int SW = 12;
  localparam int AW = SW + 2;
  localparam int SMAX = (1 << (SW - 1)) - 1;
  localparam int SMIN = -(1 << (SW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [1:0]    phase;
  logic          spin, coil, valid;
  logic [AW-1:0] sig, rf, off;

  int checks = 0, failures = 0, cycles = 0;
  int bphase = 0;
  int smp [4];
  int e_sig = 0, e_ref = 0, e_off = 0;
  bit e_valid = 0;

  always #5 clk = ~clk;

  quad_phase_demod #(.SAMPLE_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .sample_i(sample),
    .phase_o(phase), .spin_o(spin), .coil_o(coil), .res_valid_o(valid),
    .sig_o(sig), .ref_o(rf), .off_o(off)
  );

  function automatic int f_sig(); return smp[0] - smp[1] + smp[2] - smp[3]; endfunction
  function automatic int f_ref(); return smp[0] - smp[1] - smp[2] + smp[3]; endfunction
  function automatic int f_off(); return smp[0] + smp[1] + smp[2] + smp[3]; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(string tag);
    chk("R2 phase", int'(phase), bphase);
    chk("R3 spin", int'(spin), (bphase % 2 == 0) ? 1 : 0);
    chk("R4 coil", int'(coil), (bphase < 2) ? 1 : 0);
    chk("R8 valid", int'(valid), int'(e_valid));
    chk({"R5 sig ", tag}, int'($signed(sig)), e_sig);
    chk({"R6 ref ", tag}, int'($signed(rf)), e_ref);
    chk({"R7 off ", tag}, int'($signed(off)), e_off);
  endtask

  task automatic cyc(bit st, int s, string tag);
    @(negedge clk);
    step = st;
    sample = SW'(s);
    @(posedge clk);
    #1;
    e_valid = 0;
    if (st) begin
      smp[bphase] = s;
      if (bphase == 3) begin
        e_valid = 1;
        e_sig = f_sig(); e_ref = f_ref(); e_off = f_off();
      end
      bphase = (bphase + 1) % 4;
    end
    check_outs(tag);
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(SMAX - SMIN)) + SMIN;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    // R1: held in reset
    chk("R1 phase", int'(phase), 0);
    chk("R1 spin", int'(spin), 1);
    chk("R1 coil", int'(coil), 1);
    chk("R1 valid", int'(valid), 0);
    chk("R1 sig", int'(sig), 0);
    chk("R1 ref", int'(rf), 0);
    chk("R1 off", int'(off), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: component model e=100 r=7 o=-30 -> 400, 28, -120
    cyc(1,  107 - 30, "model"); cyc(1, -107 - 30, "model");
    cyc(1,   93 - 30, "model"); cyc(1,  -93 - 30, "model");
    chk("R5 4x ext", e_sig, 400);
    chk("R6 4x ref", e_ref, 28);
    chk("R7 4x off", e_off, -120);

    // R9 extremes
    cyc(1, SMAX, "R9"); cyc(1, SMIN, "R9"); cyc(1, SMAX, "R9"); cyc(1, SMIN, "R9");
    cyc(1, SMAX, "R9"); cyc(1, SMIN, "R9"); cyc(1, SMIN, "R9"); cyc(1, SMAX, "R9");
    cyc(1, SMIN, "R9"); cyc(1, SMIN, "R9"); cyc(1, SMIN, "R9"); cyc(1, SMIN, "R9");
    cyc(1, SMAX, "R9"); cyc(1, SMAX, "R9"); cyc(1, SMAX, "R9"); cyc(1, SMAX, "R9");

    // R10 idle cycles with noise inside a cycle
    cyc(1, 5, "R10"); cyc(0, SMIN, "R10"); cyc(0, SMAX, "R10");
    cyc(1, -9, "R10"); cyc(0, 1234, "R10"); cyc(1, 77, "R10");
    cyc(0, -2000, "R10"); cyc(1, 3, "R10"); cyc(0, 999, "R10"); cyc(0, -1, "R10");

    // random, mixed gaps and back-to-back
    for (int i = 0; i < 2000; i++) begin
      bit st = ($urandom_range(3) != 0);
      cyc(st, rnd_s(), st ? "rand" : "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule